// File: doc/BRIEF.md
# Ping-pong word-to-pin pattern serialiser

This block turns a stream of 32-bit words into a timed pattern on up to four output pins. A producer (normally a DMA engine) pushes words through a valid/ready write port. The block keeps two 16-word stores and uses them in turn. While one store is shifted out to the pins, the producer refills the other, so memory latency stays hidden from the pin timing.

On each pulse of an external sample-rate strobe, one sample leaves the active store. A sample is 1, 2 or 4 bits wide, chosen by a lane-select input. Samples come from the word lowest field first. The output amount is set only in whole words: a store always holds exactly 16 words, and there is no way to request a partial word of samples.

When the first sample of a store's final word reaches the pins, the block can raise a timestamp pulse of a fixed minimum width. If a store runs dry while the other store has not been refilled, the block raises a sticky overrun flag and holds the pins.

Top module: `gpio_pattern_gen`

## Requirements
- R1: `laneSel` sets the sample width. The value 0 gives 1 bit per sample and 32 samples per word. The value 1 gives 2 bits and 16 samples per word. The values 2 and 3 give 4 bits and 8 samples per word.
- R2: Sample k of a word occupies word bits [k*W+W-1 : k*W], where W is the sample width. Bit k*W+j of the word drives `pinOut[j]`. Pins at index W and above are driven 0 whenever a sample is shifted.
- R3: Exactly one sample is shifted on each clock edge where `sampleStrobe` is high and a store is loaded. `pinOut` changes one cycle after the strobe and does not change in any cycle that follows a clock edge without a strobe.
- R4: A word is accepted on each clock edge where `wrValid` and `wrReady` are both high. After 16 accepted words, the store being filled is marked loaded and filling moves to the other store. The first store to fill after reset is the first store to drain.
- R5: While both stores are loaded, `wrReady` is 0 and any word presented is dropped.
- R6: Stores drain in the order they were filled, and each store drains its words in the order they were written. A store becomes free again as soon as its final sample has been shifted.
- R7: When `eventEn` is 1 during the shift of sample 0 of word 15 of a store, `lastWordEvt` rises in the following cycle. It then stays high for `PULSE_CYCLES` cycles. When `eventEn` is 0, no pulse is produced.
- R8: When a store's final sample is shifted and the other store is not loaded, `overrun` goes to 1. It stays at 1 until a cycle with `overrunClr` high. While no store is loaded, strobes leave `pinOut` unchanged.
- R9: After reset, `pinOut` is 0, `wrReady` is 1, `lastWordEvt` is 0 and `overrun` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrValid | input | 1 | Write word valid |
| wrData | input | 32 | Write word |
| wrReady | output | 1 | Block can accept a word |
| sampleStrobe | input | 1 | One-cycle sample-rate tick |
| laneSel | input | 2 | Sample width: 0 = 1 pin, 1 = 2 pins, 2 or 3 = 4 pins |
| eventEn | input | 1 | Enable for the last-word timestamp pulse |
| overrunClr | input | 1 | Write-one-to-clear for the overrun flag |
| pinOut | output | 4 | Pattern output pins |
| lastWordEvt | output | 1 | Last-word timestamp pulse |
| overrun | output | 1 | Sticky refill-too-late flag |

## Verification
A wrong fill or drain pointer shows up as a reconstructed word that differs from the word written, at most one word (8 to 32 strobes) after the fault. A wrong sample index shows the same way within the same word. A wrong loaded flag shows within one store period as one of these: `wrReady` going low too early or too late, a store being replayed, or `overrun` taking the wrong value at the final sample. An error in the pulse counter changes the number of cycles for which `lastWordEvt` is high, and this is measured directly.

// File: rtl/gpio_pg_pkg.sv
package gpio_pg_pkg;
  localparam int WORD_W    = 32;
  localparam int BUF_WORDS = 16;
  localparam int PIN_N     = 4;
  localparam int IDX_W     = $clog2(BUF_WORDS);
  localparam int SAMP_W    = $clog2(WORD_W);

  typedef struct packed {
    logic              wrEn;
    logic              wrBuf;
    logic [IDX_W-1:0]  wrIdx;
    logic              shiftEn;
    logic              rdBuf;
    logic [IDX_W-1:0]  rdIdx;
    logic [SAMP_W-1:0] sampIdx;
  } pgCtl_t;
endpackage

// File: rtl/pg_ctrl.sv
module pg_ctrl
  import gpio_pg_pkg::*;
#(
  parameter int PULSE_CYCLES = 15
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrValid,
  output logic       wrReady,
  input  logic       sampleStrobe,
  input  logic [1:0] laneSel,
  input  logic       eventEn,
  input  logic       overrunClr,
  output pgCtl_t     ctl,
  output logic       lastWordEvt,
  output logic       overrun
);
  localparam int CNT_W = $clog2(PULSE_CYCLES + 1);

  logic              fillSel, drainSel;
  logic [IDX_W-1:0]  fillCnt, rdIdx;
  logic [SAMP_W-1:0] sampIdx, lastSampIdx;
  logic [1:0]        bufFull, bufFullNxt;
  logic [CNT_W-1:0]  evtCnt;
  logic              wrFire, fillDone, shiftEn, lastSamp, lastWord, bufDone;

  always_comb begin
    unique case (laneSel)
      2'd0:    lastSampIdx = SAMP_W'(WORD_W - 1);
      2'd1:    lastSampIdx = SAMP_W'(WORD_W / 2 - 1);
      default: lastSampIdx = SAMP_W'(WORD_W / 4 - 1);
    endcase
  end

  assign wrReady  = !bufFull[fillSel];
  assign wrFire   = wrValid && wrReady;
  assign fillDone = wrFire && (fillCnt == IDX_W'(BUF_WORDS - 1));
  assign shiftEn  = sampleStrobe && bufFull[drainSel];
  assign lastSamp = sampIdx >= lastSampIdx;
  assign lastWord = rdIdx == IDX_W'(BUF_WORDS - 1);
  assign bufDone  = shiftEn && lastSamp && lastWord;

  always_comb begin
    bufFullNxt = bufFull;
    if (fillDone) bufFullNxt[fillSel]  = 1'b1;
    if (bufDone)  bufFullNxt[drainSel] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fillSel <= 1'b0;
      fillCnt <= '0;
      bufFull <= '0;
    end else begin
      bufFull <= bufFullNxt;
      if (wrFire) begin
        fillCnt <= fillDone ? '0 : fillCnt + 1'b1;
        if (fillDone) fillSel <= !fillSel;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      drainSel <= 1'b0;
      rdIdx    <= '0;
      sampIdx  <= '0;
    end else if (shiftEn) begin
      if (lastSamp) begin
        sampIdx <= '0;
        rdIdx   <= lastWord ? '0 : rdIdx + 1'b1;
        if (lastWord) drainSel <= !drainSel;
      end else begin
        sampIdx <= sampIdx + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      evtCnt  <= '0;
      overrun <= 1'b0;
    end else begin
      if (shiftEn && eventEn && lastWord && sampIdx == '0)
        evtCnt <= CNT_W'(PULSE_CYCLES);
      else if (evtCnt != '0)
        evtCnt <= evtCnt - 1'b1;
      if (bufDone && !bufFull[!drainSel]) overrun <= 1'b1;
      else if (overrunClr)                overrun <= 1'b0;
    end
  end

  assign lastWordEvt = evtCnt != '0;

  always_comb begin
    ctl         = '0;
    ctl.wrEn    = wrFire;
    ctl.wrBuf   = fillSel;
    ctl.wrIdx   = fillCnt;
    ctl.shiftEn = shiftEn;
    ctl.rdBuf   = drainSel;
    ctl.rdIdx   = rdIdx;
    ctl.sampIdx = sampIdx;
  end

  AST_WR_BLOCKED: assert property (@(posedge clk) disable iff (!rstN)
    (bufFull == 2'b11) |-> !wrReady); // R5
  AST_EVT_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lastWordEvt) |-> $past(eventEn && sampleStrobe)); // R7
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (overrun && !overrunClr) |=> overrun); // R8
  AST_DRAIN_NEEDS_FILL: assert property (@(posedge clk) disable iff (!rstN)
    (bufFull == 2'b00) |=> $stable(rdIdx) && $stable(sampIdx)); // R8
endmodule

// File: rtl/pg_datapath.sv
module pg_datapath
  import gpio_pg_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  pgCtl_t            ctl,
  input  logic [WORD_W-1:0] wrData,
  input  logic [1:0]        laneSel,
  output logic [PIN_N-1:0]  pinOut
);
  logic [WORD_W-1:0] store [2][BUF_WORDS];
  logic [WORD_W-1:0] curWord, shifted;
  logic [PIN_N-1:0]  laneMask, nextPins;

  for (genvar b = 0; b < 2; b++) begin : g_store
    always_ff @(posedge clk) begin
      if (ctl.wrEn && ctl.wrBuf == b[0])
        store[b][ctl.wrIdx] <= wrData;
    end
  end

  assign curWord = store[ctl.rdBuf][ctl.rdIdx];

  always_comb begin
    unique case (laneSel)
      2'd0:    shifted = curWord >> ctl.sampIdx;
      2'd1:    shifted = curWord >> {ctl.sampIdx[SAMP_W-2:0], 1'b0};
      default: shifted = curWord >> {ctl.sampIdx[SAMP_W-3:0], 2'b00};
    endcase
  end

  for (genvar l = 0; l < PIN_N; l++) begin : g_lane
    assign laneMask[l] = (l == 0) || (l == 1 && laneSel != 2'd0) || (laneSel[1]);
  end

  assign nextPins = shifted[PIN_N-1:0] & laneMask;

  always_ff @(posedge clk) begin
    if (!rstN)            pinOut <= '0;
    else if (ctl.shiftEn) pinOut <= nextPins;
  end

  AST_UNUSED_PINS: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.shiftEn && laneSel == 2'd0) |=> (pinOut[PIN_N-1:1] == '0)); // R2
endmodule

// File: rtl/gpio_pattern_gen.sv
module gpio_pattern_gen
  import gpio_pg_pkg::*;
#(
  parameter int PULSE_CYCLES = 15
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrValid,
  input  logic [31:0] wrData,
  output logic        wrReady,
  input  logic        sampleStrobe,
  input  logic [1:0]  laneSel,
  input  logic        eventEn,
  input  logic        overrunClr,
  output logic [3:0]  pinOut,
  output logic        lastWordEvt,
  output logic        overrun
);
  pgCtl_t ctl;

  pg_ctrl #(.PULSE_CYCLES(PULSE_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrReady(wrReady),
    .sampleStrobe(sampleStrobe), .laneSel(laneSel), .eventEn(eventEn),
    .overrunClr(overrunClr), .ctl(ctl), .lastWordEvt(lastWordEvt),
    .overrun(overrun)
  );

  pg_datapath u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .wrData(wrData),
    .laneSel(laneSel), .pinOut(pinOut)
  );

  AST_HOLD_NO_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    !sampleStrobe |=> $stable(pinOut)); // R3
endmodule

// File: tb/gpio_pattern_gen_bench.sv
module gpio_pattern_gen_bench;
  localparam int PULSE = 15;
  localparam logic [33:0] VEC [4] = '{
    {2'd0, 32'hA5C3_0F1E}, {2'd1, 32'h1234_5678},
    {2'd2, 32'hDEAD_BEEF}, {2'd3, 32'h0F0F_3C3C}};

  logic clk = 1'b0, rstN = 1'b0;
  logic wrValid = 1'b0, sampleStrobe = 1'b0, eventEn = 1'b0, overrunClr = 1'b0;
  logic [31:0] wrData = '0;
  logic [1:0]  laneSel = '0;
  logic        wrReady, lastWordEvt, overrun;
  logic [3:0]  pinOut;
  int nChk = 0, nFail = 0;
  bit done = 0;
  logic [31:0] expW [32];

  gpio_pattern_gen #(.PULSE_CYCLES(PULSE)) u_gpio_pattern_gen (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrData(wrData), .wrReady(wrReady),
    .sampleStrobe(sampleStrobe), .laneSel(laneSel), .eventEn(eventEn),
    .overrunClr(overrunClr), .pinOut(pinOut), .lastWordEvt(lastWordEvt),
    .overrun(overrun));

  always #5 clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mkWord(logic [31:0] seed, int i);
    return seed ^ (i * 32'h9E37_79B9) ^ (32'(i) << 7);
  endfunction

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; wrValid = 1'b0; sampleStrobe = 1'b0; overrunClr = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic loadWords(input int n);
    for (int i = 0; i < n; i++) begin
      wrValid = 1'b1; wrData = expW[i];
      @(negedge clk);
    end
    wrValid = 1'b0;
  endtask

  initial begin
    #500000;
    if (!done) begin
      nFail++; nChk++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("%0d/%0d checks passed", nChk - nFail, nChk);
      $finish;
    end
  end

  initial begin
    // R9: reset state
    doReset();
    check(pinOut == 4'h0, "R9 pins", 32'(pinOut), 0);
    check(wrReady == 1'b1, "R9 wrReady", 32'(wrReady), 1);
    check(lastWordEvt == 1'b0, "R9 event", 32'(lastWordEvt), 0);
    check(overrun == 1'b0, "R9 overrun", 32'(overrun), 0);

    for (int v = 0; v < 4; v++) begin
      automatic int w, spw;
      automatic logic prevEvt = 1'b0;
      doReset();
      laneSel = VEC[v][33:32];
      w = (laneSel == 2'd0) ? 1 : (laneSel == 2'd1) ? 2 : 4;
      spw = 32 / w;
      eventEn = 1'b1;
      for (int i = 0; i < 32; i++) expW[i] = mkWord(VEC[v][31:0], i + v);
      loadWords(16);
      check(wrReady == 1'b1, "R4 second store open", 32'(wrReady), 1);
      for (int i = 0; i < 16; i++) begin
        wrValid = 1'b1; wrData = expW[16 + i];
        @(negedge clk);
      end
      check(wrReady == 1'b0, "R5 both loaded", 32'(wrReady), 0);
      wrData = 32'hFFFF_FFFF;          // R5: dropped word
      @(negedge clk);
      wrValid = 1'b0;
      sampleStrobe = 1'b1;
      for (int wi = 0; wi < 32; wi++) begin
        automatic logic [31:0] acc = '0;
        for (int s = 0; s < spw; s++) begin
          @(negedge clk);
          acc |= (32'(pinOut) & ((32'd1 << w) - 1)) << (s * w);
          if (s == 0 && w < 4)
            check((pinOut >> w) == 0, "R2 unused pins", 32'(pinOut), 32'(pinOut) & ((32'd1 << w) - 1));
          if (wi % 16 == 15 && s == 0)
            check(lastWordEvt && !prevEvt, "R7 event rise", 32'(lastWordEvt), 1);
          if (wi == 15 && s == spw - 1)
            check(overrun == 1'b0, "R8 no overrun when refilled", 32'(overrun), 0);
          if (wi == 31 && s == spw - 1)
            check(overrun == 1'b1, "R8 overrun at dry store", 32'(overrun), 1);
          prevEvt = lastWordEvt;
        end
        check(acc == expW[wi], "R1 R6 word order", acc, expW[wi]);
      end
      begin
        automatic logic [3:0] held = pinOut;
        repeat (5) begin
          @(negedge clk);
          check(pinOut == held, "R8 hold while starved", 32'(pinOut), 32'(held));
        end
      end
      sampleStrobe = 1'b0;
      check(wrReady == 1'b1, "R6 store freed", 32'(wrReady), 1);
      overrunClr = 1'b1;
      @(negedge clk);
      overrunClr = 1'b0;
      check(overrun == 1'b0, "R8 clear", 32'(overrun), 0);
    end

    // R7 pulse width, R3 stability with sparse strobes
    begin
      automatic int hi = 0;
      automatic logic [3:0] last;
      automatic logic prevStb = 1'b0;
      doReset();
      laneSel = 2'd2; eventEn = 1'b1;
      for (int i = 0; i < 16; i++) expW[i] = mkWord(32'h5A5A_1234, i);
      loadWords(16);
      last = pinOut;
      for (int c = 0; c < 128 * 3 + 40; c++) begin
        sampleStrobe = (c % 3 == 0);
        prevStb = sampleStrobe;
        @(negedge clk);
        if (!prevStb) check(pinOut == last, "R3 no strobe no change", 32'(pinOut), 32'(last));
        last = pinOut;
        if (lastWordEvt) hi++;
      end
      sampleStrobe = 1'b0;
      check(hi == PULSE, "R7 pulse width", 32'(hi), PULSE);
      check(overrun == 1'b1, "R8 single store overrun", 32'(overrun), 1);
    end

    // R7 disabled event
    begin
      automatic int hi = 0;
      doReset();
      laneSel = 2'd2; eventEn = 1'b0;
      loadWords(16);
      sampleStrobe = 1'b1;
      repeat (150) begin
        @(negedge clk);
        if (lastWordEvt) hi++;
      end
      sampleStrobe = 1'b0;
      check(hi == 0, "R7 disabled", 32'(hi), 0);
    end

    done = 1;
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end
endmodule